// File: doc/BRIEF.md
# Ring-Oscillator Delay Measurement Counter

This block measures how fast an on-chip ring oscillator runs so that the propagation delay of the inverter chain inside it can be tracked as the silicon ages. On request it waits for the next rising edge of a slow reference clock, then counts oscillator rising edges while the reference is high. One half reference period is the window, so the oscillator frequency is twice the count times the reference frequency. The path delay through the chain is 1 / (4 x count x reference frequency), which means a slower, aged path gives a smaller count.

The edge counter runs in the oscillator's own clock domain. At the end of each window it stores the result and flips a toggle flag. The flag is synchronised into the system clock domain, where the result is captured and presented for one cycle with a valid strobe. The same block drives the oscillator's enable line. That line selects the stress applied to the chain: held low, the chain sits static (constant stress); held high, it switches continuously (switching stress). The enable line is raised for the length of a measurement. It is held high all the time when switching-stress mode is selected, and it is raised while reset is applied so that the oscillator domain is clocked and can see the reset. A count that reaches the counter's full scale stops there and is reported with an overflow flag.

Top module: `ror_delay_meter`

## Requirements
- R1: While `rst_n` is low, `valid_o`, `busy_o` and `ovf_o` are 0, `count_o` is 0 and `osc_en_o` is 1 from the first clock edge of reset.
- R2: With `ac_mode_i` low and no measurement in progress, `osc_en_o` is 0. A request raises `busy_o` and `osc_en_o` on the next clock edge, and both stay high until the result is delivered. They drop in the same cycle that `valid_o` is high.
- R3: While `ac_mode_i` is high, `osc_en_o` is 1 from the next clock edge on, including while idle and after a result is delivered.
- R4: A one-cycle pulse on `meas_req_i` while idle starts a measurement. The counting window is the high half of the first full reference period that begins after the request. `count_o` reports the number of oscillator rising edges in that window, within plus or minus 3 of the half period divided by the oscillator period.
- R5: If the window holds more edges than the counter's full scale (2^CNT_W - 1), the counter stops at full scale instead of wrapping. `count_o` then reports full scale and `ovf_o` is 1.
- R6: Each measurement produces exactly one `valid_o` pulse lasting one clock cycle. `count_o` and `ovf_o` take their new values in that cycle and hold them until the next result.
- R7: A pulse on `meas_req_i` while `busy_o` is high is ignored. No second measurement or second `valid_o` pulse follows from it.
- R8: `ovf_o` returns to 0 with the first result whose count is below full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_i | input | 1 | Slow reference clock; its high half sets the counting window |
| osc_i | input | 1 | Ring-oscillator output; edges are counted in this clock domain |
| ac_mode_i | input | 1 | 1 holds the oscillator running permanently (switching stress) |
| meas_req_i | input | 1 | One-cycle pulse that starts a measurement |
| osc_en_o | output | 1 | Enable for the ring oscillator |
| count_o | output | CNT_W | Oscillator edges counted in the last window |
| ovf_o | output | 1 | Last count reached full scale |
| valid_o | output | 1 | One-cycle strobe marking a new result |
| busy_o | output | 1 | A measurement is in progress |

## Verification
The bench sweeps the oscillator period so that the count changes inversely with period. A design that counted a full reference period, or that ignored the window, would miss the expected count by a factor of two or more. A directed run with a very fast oscillator pushes the count past full scale. A wrapping counter would report a small value with no overflow, and a sticky flag would fail the clean measurement that follows. Extra requests are fired while a measurement is still in progress; a design that re-armed on them would emit a second strobe. The enable line is sampled when idle, while busy, in the cycle of the result strobe and under switching stress. A late or missing release of the line would show up in those samples.

// File: rtl/ror_pkg.sv
// Shared types for the ring-oscillator delay meter.
package ror_pkg;

    // Measurement sequence in the system clock domain
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // no measurement
        ST_ARMED = 2'd1,  // waiting for a reference rising edge
        ST_GATE  = 2'd2,  // window open, reference high
        ST_WAIT  = 2'd3   // window closed, waiting for the result
    } meas_state_t;

endpackage

// File: rtl/ror_sync.sv
// Multi-flop level synchroniser.
// Assumes: the input is a level that stays put for several destination cycles.
module ror_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], d_i};
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ror_ctrl.sv
// Measurement sequencer in the system clock domain.
// Synchronises the reference clock, opens the counting window on a reference
// rising edge, closes it on the next falling edge, and waits for the result
// to come back from the oscillator domain. Also drives the oscillator enable.
// Assumes: the reference clock is far slower than clk.
module ror_ctrl
    import ror_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk_i,
    input  logic ac_mode_i,
    input  logic meas_req_i,
    input  logic done_i,
    output logic gate_o,
    output logic osc_en_o,
    output logic busy_o
);
    meas_state_t state, state_nx;
    logic ref_s, ref_d;
    logic ref_rise, ref_fall;

    ror_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk (clk),
        .d_i (ref_clk_i),
        .q_o (ref_s)
    );

    // Remember the last synchronised reference level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) ref_d <= 1'b0;
        else        ref_d <= ref_s;
    end

    assign ref_rise = ref_s & ~ref_d;
    assign ref_fall = ~ref_s & ref_d;

    // Next-state decode of the measurement sequence
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (meas_req_i) state_nx = ST_ARMED;
            ST_ARMED: if (ref_rise)   state_nx = ST_GATE;
            ST_GATE:  if (ref_fall)   state_nx = ST_WAIT;
            ST_WAIT:  if (done_i)     state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    // State, window gate and oscillator enable registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            gate_o   <= 1'b0;
            osc_en_o <= 1'b1;
        end else begin
            state    <= state_nx;
            gate_o   <= (state_nx == ST_GATE);
            osc_en_o <= ac_mode_i | (state_nx != ST_IDLE);
        end
    end

    assign busy_o = (state != ST_IDLE);

    // R2: the oscillator runs for the whole of a measurement
    p_en_while_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> osc_en_o);

    // R3: switching-stress mode keeps the oscillator running
    p_ac_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ac_mode_i |=> osc_en_o);

    // R4: the window only opens from the armed state
    p_gate_from_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_o) |-> $past(state) == ST_ARMED);
endmodule

// File: rtl/ror_edge_counter.sv
// Oscillator-domain edge counter.
// Follows the synchronised window gate: it clears on the gate's rising edge,
// counts while the gate is high and saturates at full scale. On the gate's
// falling edge it stores the count and overflow bit and flips a toggle flag.
// Assumes: the oscillator runs whenever reset or a window is in progress.
module ror_edge_counter #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             osc_clk,
    input  logic             rst_n,
    input  logic             gate_i,
    output logic [CNT_W-1:0] hold_o,
    output logic             hold_ovf_o,
    output logic             tog_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             orst_n;
    logic             gate_s, gate_d;
    logic             win_open, win_close;
    logic [CNT_W-1:0] cnt;

    ror_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
        .clk (osc_clk),
        .d_i (rst_n),
        .q_o (orst_n)
    );

    ror_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
        .clk (osc_clk),
        .d_i (gate_i),
        .q_o (gate_s)
    );

    assign win_open  = gate_s & ~gate_d;
    assign win_close = ~gate_s & gate_d;

    // Count edges inside the window, saturating at full scale
    always_ff @(posedge osc_clk) begin
        if (!orst_n) begin
            gate_d <= 1'b0;
            cnt    <= '0;
        end else begin
            gate_d <= gate_s;
            if (win_open)
                cnt <= '0;
            else if (gate_s && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end
    end

    // Store the result and signal it across with a toggle
    always_ff @(posedge osc_clk) begin
        if (!orst_n) begin
            hold_o     <= '0;
            hold_ovf_o <= 1'b0;
            tog_o      <= 1'b0;
        end else if (win_close) begin
            hold_o     <= cnt;
            hold_ovf_o <= (cnt == CNT_MAX);
            tog_o      <= ~tog_o;
        end
    end

    // R5: a full-scale count never wraps within the window
    p_no_wrap_r5: assert property (@(posedge osc_clk) disable iff (!orst_n)
        (cnt == CNT_MAX && !win_open) |=> cnt == CNT_MAX);

    // R5: a stored overflow always comes with a full-scale count
    p_ovf_full_r5: assert property (@(posedge osc_clk) disable iff (!orst_n)
        hold_ovf_o |-> hold_o == CNT_MAX);
endmodule

// File: rtl/ror_result_sync.sv
// System-domain result capture.
// Synchronises the oscillator-domain toggle. On each change it captures the
// stored count and overflow bit and raises valid for one cycle.
// Assumes: the stored result stays stable for many system cycles after a toggle.
module ror_result_sync #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tog_i,
    input  logic [CNT_W-1:0] hold_i,
    input  logic             hold_ovf_i,
    output logic             done_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             valid_o
);
    logic tog_s, tog_d;

    ror_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
        .clk (clk),
        .d_i (tog_i),
        .q_o (tog_s)
    );

    assign done_o = tog_s ^ tog_d;

    // Capture the result and produce a one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_d   <= 1'b0;
            count_o <= '0;
            ovf_o   <= 1'b0;
            valid_o <= 1'b0;
        end else begin
            tog_d   <= tog_s;
            valid_o <= done_o;
            if (done_o) begin
                count_o <= hold_i;
                ovf_o   <= hold_ovf_i;
            end
        end
    end

    // R6: valid is a single-cycle strobe
    p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R6: outputs hold between strobes
    p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(count_o));
endmodule

// File: rtl/ror_delay_meter.sv
// Ring-oscillator delay meter, top level.
// Counts oscillator edges over one high half of the reference clock, per
// request, and reports the count with a one-cycle valid strobe in the clk
// domain. Drives the oscillator enable (stress-mode selector).
// Assumes: osc_i only toggles while osc_en_o is high.
module ror_delay_meter #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_i,
    input  logic             osc_i,
    input  logic             ac_mode_i,
    input  logic             meas_req_i,
    output logic             osc_en_o,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_o,
    output logic             valid_o,
    output logic             busy_o
);
    logic             gate;
    logic             done;
    logic [CNT_W-1:0] hold;
    logic             hold_ovf;
    logic             tog;

    ror_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_clk_i  (ref_clk_i),
        .ac_mode_i  (ac_mode_i),
        .meas_req_i (meas_req_i),
        .done_i     (done),
        .gate_o     (gate),
        .osc_en_o   (osc_en_o),
        .busy_o     (busy_o)
    );

    ror_edge_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_counter (
        .osc_clk    (osc_i),
        .rst_n      (rst_n),
        .gate_i     (gate),
        .hold_o     (hold),
        .hold_ovf_o (hold_ovf),
        .tog_o      (tog)
    );

    ror_result_sync #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_result (
        .clk        (clk),
        .rst_n      (rst_n),
        .tog_i      (tog),
        .hold_i     (hold),
        .hold_ovf_i (hold_ovf),
        .done_o     (done),
        .count_o    (count_o),
        .ovf_o      (ovf_o),
        .valid_o    (valid_o)
    );

    // R6: every result strobe closes a measurement that was in progress
    p_valid_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ($past(busy_o) && !busy_o));
endmodule

// File: tb/ror_delay_meter_bench.sv
`timescale 1ns/1ps
module ror_delay_meter_bench;
    localparam int      CNT_W    = 12;
    localparam int      CNT_MAX  = (1 << CNT_W) - 1;
    localparam realtime REF_HALF = 5000.0;
    localparam int      TOL      = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_clk = 1'b0;
    logic             osc = 1'b0;
    logic             ac_mode = 1'b0;
    logic             meas_req = 1'b0;
    logic             osc_en;
    logic [CNT_W-1:0] count;
    logic             ovf;
    logic             valid;
    logic             busy;

    realtime osc_period = 4.0;
    int      n_tests = 0;
    int      n_fail  = 0;
    int      last_count;
    int      last_ovf;
    bit      got_valid;

    ror_delay_meter #(.CNT_W(CNT_W)) u_ror_delay_meter (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_clk_i  (ref_clk),
        .osc_i      (osc),
        .ac_mode_i  (ac_mode),
        .meas_req_i (meas_req),
        .osc_en_o   (osc_en),
        .count_o    (count),
        .ovf_o      (ovf),
        .valid_o    (valid),
        .busy_o     (busy)
    );

    always #2.5 clk = ~clk;
    always #(REF_HALF) ref_clk = ~ref_clk;

    // Ring oscillator model: runs only while enabled
    initial begin
        forever begin
            if (osc_en === 1'b1) begin
                #(osc_period / 2.0) osc = ~osc;
            end else begin
                osc = 1'b0;
                @(posedge osc_en);
            end
        end
    end

    function automatic int exp_count(realtime period);
        int n;
        n = $rtoi(REF_HALF / period);
        return (n > CNT_MAX) ? CNT_MAX : n;
    endfunction

    task automatic check(bit ok, string req, int actual, int expected);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // One measurement: request, wait for the strobe, sample at negedges
    task automatic measure(bit extra_req);
        got_valid = 1'b0;
        @(negedge clk);
        meas_req = 1'b1;
        @(negedge clk);
        meas_req = 1'b0;
        check(busy == 1'b1 && osc_en == 1'b1, "R2 busy/enable after request", busy, 1);
        for (int i = 0; i < 8000 && !got_valid; i++) begin
            @(negedge clk);
            if (extra_req && i == 1500) meas_req = 1'b1;
            else meas_req = 1'b0;
            if (valid) got_valid = 1'b1;
        end
        check(got_valid, "R6 valid strobe seen", got_valid, 1);
        last_count = count;
        last_ovf   = ovf;
        check(busy == 1'b0, "R2 busy drops with valid", busy, 0);
        check(osc_en == ac_mode, "R2/R3 enable after result", osc_en, ac_mode);
        @(negedge clk);
        check(valid == 1'b0, "R6 valid single cycle", valid, 0);
    endtask

    task automatic check_count(string req);
        int e;
        e = exp_count(osc_period);
        check(last_count >= e - TOL && last_count <= e + TOL, req, last_count, e);
        check(last_ovf == ((e == CNT_MAX) ? 1 : 0), "R5/R8 overflow flag", last_ovf,
              (e == CNT_MAX) ? 1 : 0);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (20) @(negedge clk);
        check(valid == 1'b0, "R1 valid in reset", valid, 0);
        check(busy == 1'b0, "R1 busy in reset", busy, 0);
        check(ovf == 1'b0, "R1 ovf in reset", ovf, 0);
        check(count == '0, "R1 count in reset", count, 0);
        check(osc_en == 1'b1, "R1 enable in reset", osc_en, 1);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R2: idle, constant stress -> enable low
        check(osc_en == 1'b0, "R2 enable idle", osc_en, 0);

        // R4: directed periods
        osc_period = 4.0;  measure(1'b0); check_count("R4 count 4ns");
        osc_period = 10.0; measure(1'b0); check_count("R4 count 10ns");
        osc_period = 20.0; measure(1'b0); check_count("R4 count 20ns");

        // R5: oscillator too fast -> saturate, no wrap
        osc_period = 1.0;  measure(1'b0);
        check(last_count == CNT_MAX, "R5 saturated count", last_count, CNT_MAX);
        check(last_ovf == 1, "R5 overflow set", last_ovf, 1);
        repeat (50) @(negedge clk);
        check(count == CNT_MAX && ovf, "R6 result held", count, CNT_MAX);

        // R8: next clean result clears the flag
        osc_period = 8.0;  measure(1'b0);
        check(last_ovf == 0, "R8 overflow cleared", last_ovf, 0);
        check_count("R4 count 8ns");

        // R7: extra request while busy is ignored
        osc_period = 6.0;  measure(1'b1);
        check_count("R7 count with extra request");
        got_valid = 1'b0;
        for (int i = 0; i < 4500; i++) begin
            @(negedge clk);
            if (valid) got_valid = 1'b1;
        end
        check(!got_valid && !busy, "R7 no second measurement", got_valid, 0);

        // R3: switching stress holds the enable
        ac_mode = 1'b1;
        repeat (3) @(negedge clk);
        check(osc_en == 1'b1, "R3 enable idle in ac mode", osc_en, 1);
        osc_period = 5.0;  measure(1'b0); check_count("R3 count in ac mode");
        ac_mode = 1'b0;
        repeat (3) @(negedge clk);
        check(osc_en == 1'b0, "R2 enable off after ac mode", osc_en, 0);

        // R4: random periods and stress modes
        for (int k = 0; k < 10; k++) begin
            osc_period = 1.5 + 0.25 * $itor($urandom_range(0, 74));
            ac_mode = 1'($urandom_range(0, 1));
            repeat (2) @(negedge clk);
            measure(1'b0);
            check_count("R4 random period");
        end
        ac_mode = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule